// File: doc/BRIEF.md
# Pin-strapped I2C register target

This block is an I2C target that answers on a 7-bit bus address built from a fixed upper part and a few strap pins, so several copies can share one bus. Inside it keeps a register pointer. The first data byte of any write transaction loads that pointer. The pointer is kept across stop conditions, so a later read transaction returns the register it selects. Pointer 0x00 selects an 8-bit temperature register, which is loaded continuously from a parallel input. Pointer 0x01 selects an 8-bit setup register that a write can change. Every other pointer value reads as zero.

The block runs from a system clock that oversamples SCL and SDA. It drives SDA in open-drain style: while `sda_oe` is high the pad pulls the line low. The controller is a state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the address byte is being shifted in.
- `ST_ADDR_ACK`: the target acknowledges its address.
- `ST_WR_BYTE` and `ST_WR_ACK`: a write byte is received and then acknowledged.
- `ST_RD_BYTE` and `ST_RD_ACK`: a read byte is shifted out, then the controller's acknowledge is sampled.
- `ST_WAIT`: the target lets go of the bus until the next start or stop.

Transitions:
- From any state, a stop goes to `ST_IDLE` and a start or repeated start goes to `ST_ADDR`.
- At the end of the address byte, a matching address goes to `ST_ADDR_ACK`. Any other address goes to `ST_WAIT`.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` or `ST_WR_BYTE`, depending on the direction bit.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK`. From there, a controller acknowledge returns to `ST_RD_BYTE` and a not-acknowledge goes to `ST_WAIT`.

Top module: `strap_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal {4'b1001, strap}, so 0x48 when all straps are low. It acknowledges by pulling SDA low during the ninth SCL clock.
- R2: After an address that does not match, SDA stays released for the rest of that transaction, including through any further bytes. SDA is also released after reset.
- R3: In a write transaction, the first data byte after the address is loaded into the register pointer, and the target acknowledges that byte.
- R4: A read with pointer 0x00 returns the value on `temp_value`, eight bits, most significant bit first.
- R5: The pointer keeps its value across a stop condition, so a separate later read returns the selected register.
- R6: Read data is captured when the read address is acknowledged. A change of `temp_value` in the middle of the byte does not alter the byte being sent.
- R7: A pointer value other than 0x00 or 0x01 is acknowledged when written, and reading it returns 0x00. Data bytes written to it are acknowledged and have no effect.
- R8: With pointer 0x01, the data bytes of a write after the pointer byte are stored in the setup register, acknowledged, and returned by later reads. Data bytes written with pointer 0x00 are acknowledged and do not change what pointer 0x00 returns.
- R9: When the controller does not acknowledge a read byte, the target releases SDA and drives nothing until the next start or stop.
- R10: When the controller acknowledges a read byte, the target sends another byte from the same register, captured at that point.
- R11: `sda_oe` changes only while SCL is low, and at least one system clock after the SCL falling edge.
- R12: A repeated start without a stop, placed between the pointer write and the read, is handled like a fresh transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| strap | input | STRAP_W | Low address bits set by pins |
| temp_value | input | 8 | Parallel temperature value returned at pointer 0x00 |

## Verification
The bench builds the block with its default parameters: three strap bits, a fixed upper address of 4'b1001 and a two-stage synchronizer. With three strap bits, every strap setting can be crossed with all eight addresses 0x48 to 0x4F, so each matching and non-matching case is exercised. With an eight-bit temperature path, the read data can be stepped across the whole byte range in even strides. The short synchronizer keeps the gap between an SCL edge and an SDA response to a few cycles. That gap lets the bench change `temp_value` partway through a byte and check that the byte being sent is not torn.

// File: rtl/strap_i2c_pkg.sv
package strap_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT
    } tgt_state_t;

    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  PTR_TEMP  = 8'h00;
    localparam logic [7:0]  PTR_SETUP = 8'h01;

endpackage

// File: rtl/strap_i2c_sync.sv
module strap_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/strap_i2c_regs.sv
module strap_i2c_regs
    import strap_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] temp_in,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr_q
);
    logic [BYTE_W-1:0] setup_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= PTR_TEMP;
            setup_q <= '0;
        end else begin
            if (ptr_we) begin
                ptr_q <= wdata;
            end
            if (data_we && ptr_q == PTR_SETUP) begin
                setup_q <= wdata;
            end
        end
    end

    always_comb begin
        case (ptr_q)
            PTR_TEMP:  rd_data = temp_in;
            PTR_SETUP: rd_data = setup_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/strap_i2c_fsm.sv
module strap_i2c_fsm
    import strap_i2c_pkg::*;
#(
    parameter int         STRAP_W   = 3,
    parameter logic [6:0] ADDR_BASE = 7'h48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_s,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               ptr_we,
    output logic               data_we,
    output logic [BYTE_W-1:0]  wdata,
    output tgt_state_t         state_o,
    output logic [BYTE_W-1:0]  shreg_o
);
    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    tgt_state_t        state_q, state_d;
    logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
    logic [BYTE_W-1:0] shreg_q, shreg_d;
    logic              rw_q, rw_d;
    logic              first_q, first_d;
    logic              mack_q, mack_d;
    logic [6:0]        own_addr;

    assign own_addr = {ADDR_BASE[6:STRAP_W], strap};

    // next-state and datapath
    always_comb begin
        state_d  = state_q;
        bitcnt_d = bitcnt_q;
        shreg_d  = shreg_q;
        rw_d     = rw_q;
        first_d  = first_q;
        mack_d   = mack_q;
        ptr_we   = 1'b0;
        data_we  = 1'b0;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d  = ST_ADDR;
            bitcnt_d = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_ADDR: begin
                    if (scl_rise && bitcnt_q < CNT_FULL) begin
                        shreg_d  = {shreg_q[BYTE_W-2:0], sda_s};
                        bitcnt_d = bitcnt_q + 1'b1;
                    end else if (scl_fall && bitcnt_q == CNT_FULL) begin
                        if (shreg_q[7:1] == own_addr) begin
                            state_d = ST_ADDR_ACK;
                            rw_d    = shreg_q[0];
                            if (shreg_q[0]) begin
                                shreg_d = rd_data;
                            end
                        end else begin
                            state_d = ST_WAIT;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt_d = '0;
                        if (rw_q) begin
                            state_d = ST_RD_BYTE;
                        end else begin
                            state_d = ST_WR_BYTE;
                            first_d = 1'b1;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise && bitcnt_q < CNT_FULL) begin
                        shreg_d  = {shreg_q[BYTE_W-2:0], sda_s};
                        bitcnt_d = bitcnt_q + 1'b1;
                    end else if (scl_fall && bitcnt_q == CNT_FULL) begin
                        state_d = ST_WR_ACK;
                        if (first_q) begin
                            ptr_we = 1'b1;
                        end else begin
                            data_we = 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        state_d  = ST_WR_BYTE;
                        bitcnt_d = '0;
                        first_d  = 1'b0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        shreg_d  = {shreg_q[BYTE_W-2:0], 1'b1};
                        bitcnt_d = bitcnt_q + 1'b1;
                        if (bitcnt_q == CNT_LAST) begin
                            state_d = ST_RD_ACK;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_s;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_d  = ST_RD_BYTE;
                            bitcnt_d = '0;
                            shreg_d  = rd_data;
                        end else begin
                            state_d = ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            rw_q     <= 1'b0;
            first_q  <= 1'b0;
            mack_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            bitcnt_q <= bitcnt_d;
            shreg_q  <= shreg_d;
            rw_q     <= rw_d;
            first_q  <= first_d;
            mack_q   <= mack_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~shreg_q[BYTE_W-1];
            default:                sda_oe = 1'b0;
        endcase
    end

    assign wdata   = shreg_q;
    assign state_o = state_q;
    assign shreg_o = shreg_q;

endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
    import strap_i2c_pkg::*;
#(
    parameter int         STRAP_W     = 3,
    parameter logic [6:0] ADDR_BASE   = 7'h48,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap,
    input  logic [7:0]         temp_value
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              ptr_we;
    logic              data_we;
    logic [BYTE_W-1:0] wdata;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] cur_ptr;
    logic [BYTE_W-1:0] cur_shreg;
    tgt_state_t        cur_state;

    strap_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    strap_i2c_fsm #(.STRAP_W(STRAP_W), .ADDR_BASE(ADDR_BASE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .ptr_we    (ptr_we),
        .data_we   (data_we),
        .wdata     (wdata),
        .state_o   (cur_state),
        .shreg_o   (cur_shreg)
    );

    strap_i2c_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_we  (ptr_we),
        .data_we (data_we),
        .wdata   (wdata),
        .temp_in (temp_value),
        .rd_data (rd_data),
        .ptr_q   (cur_ptr)
    );

endmodule

// File: rtl/strap_i2c_checker.sv
module strap_i2c_checker
    import strap_i2c_pkg::*;
#(
    parameter int         STRAP_W   = 3,
    parameter logic [6:0] ADDR_BASE = 7'h48
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_i,
    input logic               sda_oe,
    input logic               scl_fall,
    input logic [STRAP_W-1:0] strap,
    input tgt_state_t         state,
    input logic [7:0]         shreg,
    input logic [7:0]         ptr_q
);
    assert_addr_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR)
            |-> $past(shreg[7:1]) == {ADDR_BASE[6:STRAP_W], strap});

    assert_ptr_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) |-> state == ST_WR_ACK);

    assert_no_tear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_BYTE && $past(state) == ST_RD_BYTE && !$past(scl_fall))
            |-> $stable(shreg));

    assert_sda_hold_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    assert_drive_in_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

endmodule

bind strap_i2c_target strap_i2c_checker #(.STRAP_W(STRAP_W), .ADDR_BASE(ADDR_BASE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .scl_fall (scl_fall),
    .strap    (strap),
    .state    (cur_state),
    .shreg    (cur_shreg),
    .ptr_q    (cur_ptr)
);

// File: tb/test_strap_i2c_target.sv
`timescale 1ns/1ps
module test_strap_i2c_target;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b000;
    logic [7:0] temp = 8'h00;
    logic       sda_oe;
    logic       sda_line;
    int         errs = 0;
    int         checks = 0;
    int         r11_viol = 0;
    logic       done = 1'b0;
    logic       prev_scl = 1'b1;
    logic       prev_oe = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    strap_i2c_target i_strap_i2c_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .strap      (strap),
        .temp_value (temp)
    );

    // R11 monitor: drive may change only while SCL is low
    always @(negedge clk) begin
        if (rst_n && scl && prev_scl && (sda_oe != prev_oe)) r11_viol++;
        prev_scl <= scl;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic seen);
        tick(Q); sda_m = b;
        tick(Q); scl = 1'b1;
        tick(Q); seen = sda_line;
        tick(Q); scl = 1'b0;
    endtask

    task automatic bus_start();
        if (scl) begin
            tick(Q); sda_m = 1'b0;
            tick(Q); scl = 1'b0;
        end else begin
            tick(Q); sda_m = 1'b1;
            tick(Q); scl = 1'b1;
            tick(Q); sda_m = 1'b0;
            tick(Q); scl = 1'b0;
        end
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0;
        tick(Q); scl = 1'b1;
        tick(Q); sda_m = 1'b1;
        tick(4*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, input int poke_at,
                             input logic [7:0] poke_val, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            if (i == poke_at) temp = poke_val;
            bit_io(1'b1, s);
            d[i] = s;
        end
        bit_io(~give_ack, s);
    endtask

    // write: address + pointer (+ optional data), each acknowledged
    task automatic write_regs(input logic [6:0] a, input logic [7:0] ptr,
                              input logic has_data, input logic [7:0] dat, input string req);
        logic ak;
        bus_start();
        send_byte({a, 1'b0}, ak); chk("R1", {7'd0, ak}, 8'd1);
        send_byte(ptr, ak);       chk(req, {7'd0, ak}, 8'd1);
        if (has_data) begin
            send_byte(dat, ak);   chk(req, {7'd0, ak}, 8'd1);
        end
    endtask

    task automatic read_one(input logic [6:0] a, input int poke_at,
                            input logic [7:0] poke_val, output logic [7:0] d);
        logic ak;
        bus_start();
        send_byte({a, 1'b1}, ak); chk("R1", {7'd0, ak}, 8'd1);
        recv_byte(1'b0, poke_at, poke_val, d);
        tick(2*Q);
        chk("R9", {7'd0, sda_oe}, 8'd0);
        bus_stop();
    endtask

    initial begin
        logic       ak;
        logic [7:0] d;
        logic [7:0] d2;
        logic [6:0] me;
        tick(4);
        chk("R2", {7'd0, sda_oe}, 8'd0);
        rst_n = 1'b1;
        tick(4);
        chk("R2", {7'd0, sda_oe}, 8'd0);

        // R1 / R2: every strap setting against every address in the group
        for (int sv = 0; sv < 8; sv++) begin
            strap = 3'(sv);
            for (int av = 0; av < 8; av++) begin
                bus_start();
                send_byte({7'h48 | 7'(av), 1'b0}, ak);
                chk("R1", {7'd0, ak}, (av == sv) ? 8'd1 : 8'd0);
                send_byte(8'h00, ak);
                chk((av == sv) ? "R3" : "R2", {7'd0, ak}, (av == sv) ? 8'd1 : 8'd0);
                bus_stop();
            end
        end

        strap = 3'b101;
        me = 7'h4D;

        // R4 / R5: pointer 0x00 set, stop, separate read returns temperature
        for (int k = 0; k < 16; k++) begin
            temp = 8'(k * 17 + (k % 3));
            write_regs(me, 8'h00, 1'b0, 8'h00, "R3");
            bus_stop();
            read_one(me, -1, 8'h00, d);
            chk("R4 R5", d, 8'(k * 17 + (k % 3)));
        end

        // R12: repeated start between pointer write and read
        temp = 8'h1A;
        write_regs(me, 8'h00, 1'b0, 8'h00, "R3");
        read_one(me, -1, 8'h00, d);
        chk("R12", d, 8'h1A);

        // R6: temperature changes mid-byte
        temp = 8'h3C;
        read_one(me, 4, 8'hC3, d);
        chk("R6", d, 8'h3C);
        read_one(me, -1, 8'h00, d);
        chk("R6", d, 8'hC3);

        // R10: controller acknowledges, second byte captured afresh
        temp = 8'h11;
        bus_start();
        send_byte({me, 1'b1}, ak); chk("R1", {7'd0, ak}, 8'd1);
        recv_byte(1'b1, 2, 8'h22, d);
        recv_byte(1'b0, -1, 8'h00, d2);
        tick(2*Q);
        chk("R9", {7'd0, sda_oe}, 8'd0);
        bus_stop();
        chk("R10", d, 8'h11);
        chk("R10", d2, 8'h22);

        // R8: setup register write and readback; temperature write ignored
        write_regs(me, 8'h01, 1'b1, 8'hA5, "R8");
        bus_stop();
        read_one(me, -1, 8'h00, d);
        chk("R8", d, 8'hA5);
        temp = 8'h47;
        write_regs(me, 8'h00, 1'b1, 8'h33, "R8");
        bus_stop();
        read_one(me, -1, 8'h00, d);
        chk("R8", d, 8'h47);

        // R7: unimplemented pointers
        write_regs(me, 8'h5C, 1'b0, 8'h00, "R7");
        bus_stop();
        read_one(me, -1, 8'h00, d);
        chk("R7", d, 8'h00);
        write_regs(me, 8'hFF, 1'b1, 8'h77, "R7");
        bus_stop();
        read_one(me, -1, 8'h00, d);
        chk("R7", d, 8'h00);
        write_regs(me, 8'h01, 1'b0, 8'h00, "R7");
        bus_stop();
        read_one(me, -1, 8'h00, d);
        chk("R7", d, 8'hA5);

        // R2: a foreign read keeps SDA released across its data clocks
        bus_start();
        send_byte({7'h48, 1'b1}, ak); chk("R2", {7'd0, ak}, 8'd0);
        recv_byte(1'b0, -1, 8'h00, d);
        chk("R2", d, 8'hFF);
        bus_stop();

        chk("R11", 8'(r11_viol), 8'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule